// File: doc/BRIEF.md
# Staggered LED Sink Update Sequencer

This block takes the pattern held for a row of constant-current LED sinks and applies it to the sink control lines one channel at a time. Any change of the effective output state is spread over a ripple that begins at channel 0 and climbs in ascending index order. Each channel follows its lower neighbour after a fixed step, and the delays add up along the row. Spreading the switching this way limits the current surge on the supply and ground planes.

The block runs on a fast timing clock. It samples three control pins that are already synchronous to that clock: an active-low output enable, a latch strobe and the serial shift clock. Three events start a ripple. The first is output enable falling. The second is the latch strobe rising while output enable is low. The third is a shift-clock rising edge while output enable is low and the latch strobe is held high, which happens when the latches are bypassed. Raising output enable turns every line off on the next edge, with no staggering, and abandons any ripple in progress.

The step is set in picoseconds and converted to timing-clock cycles when the block is elaborated. The default step equals one cycle of a 50 MHz timing clock.

Top module: `led_stagger_seq`

## Requirements
- R1: After reset every drive line is 0 and busy is 0.
- R2: A falling edge of out_en_n is a trigger. On the clock edge that first samples out_en_n low, drive[0] takes the value of pattern[0] sampled on that same edge.
- R3: A rising edge of latch_en while out_en_n is low is a trigger.
- R4: A rising edge of shift_clk while out_en_n is low and latch_en is high is a trigger. A rising edge of shift_clk while latch_en is low leaves drive unchanged.
- R5: After a trigger on edge E, channel k takes its new value on edge E + k*STEP, where STEP = STEP_PS / CLK_PERIOD_PS. The channels update in ascending order. Before its update edge, a channel keeps its previous value.
- R6: The pattern is captured on the trigger edge. Changes to pattern during the ripple do not reach channels 1 to N-1.
- R7: A trigger that arrives during a ripple restarts the ripple from channel 0 using the newest pattern. Channels that were not updated yet keep their current value until their new update edge.
- R8: The edge that samples out_en_n high clears all drive lines at once and clears busy, which cancels any ripple.
- R9: busy is 1 after the trigger edge and drops on the edge that updates the last channel, so it stays high for (N-1)*STEP cycles.
- R10: With no trigger and no ripple, drive holds its value whatever pattern does.
- R11: A rising edge of latch_en or shift_clk while out_en_n is high starts no ripple, and the drive lines stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| out_en_n | input | 1 | Active-low output enable, sampled each cycle |
| latch_en | input | 1 | Latch strobe, sampled each cycle |
| shift_clk | input | 1 | Serial shift clock, sampled each cycle |
| pattern | input | CHANNELS | Target on/off pattern from the latches |
| drive | output | CHANNELS | Staggered sink control lines, 1 = sink on |
| busy | output | 1 | High while a ripple is in progress |

## Verification
The bench builds the block with five channels and a 60 ns step against the 20 ns clock, so each step takes three cycles. This configuration uses the step-divider variant, and a full ripple is short enough to be checked cycle by cycle. It sweeps all 32 five-channel patterns, and each pattern ripples over the one before it, so every rising and falling transition on every channel is compared against an arithmetic model of the update edge k*STEP. With a small channel count, the bench can also restart a ripple partway through and blank the outputs mid-ripple while the channels hold a mix of old and new values.

// File: rtl/lss_pkg.sv
`timescale 1ns/1ps
package lss_pkg;

   // Control pin levels as sampled on one timing-clock edge.
   typedef struct packed {
      logic oe_n;
      logic le;
      logic sck;
   } pin_sample_t;

   // Converts the stagger step from picoseconds to whole clock cycles.
   function automatic int step_cycles(input int step_ps, input int clk_ps);
      return step_ps / clk_ps;
   endfunction

endpackage

// File: rtl/lss_trigger.sv
`timescale 1ns/1ps
module lss_trigger (
   input  logic clk,
   input  logic rst_n,
   input  lss_pkg::pin_sample_t pins,
   output logic fire,
   output logic blank
);
   lss_pkg::pin_sample_t prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q.oe_n <= 1'b1;
         prev_q.le   <= 1'b0;
         prev_q.sck  <= 1'b0;
      end else begin
         prev_q <= pins;
      end
   end

   logic oe_fall, le_rise, sck_bypass;
   assign oe_fall    = prev_q.oe_n;
   assign le_rise    = pins.le && !prev_q.le;
   assign sck_bypass = pins.le && pins.sck && !prev_q.sck;

   assign fire  = !pins.oe_n && (oe_fall || le_rise || sck_bypass);
   assign blank = pins.oe_n;

   // R11: no ripple can start while outputs are disabled
   assert_fire_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> !pins.oe_n);
endmodule

// File: rtl/lss_step_timer.sv
`timescale 1ns/1ps
module lss_step_timer #(
   parameter int CHANNELS = 16,
   parameter int STEP_CYC = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                cancel,
   output logic                busy,
   output logic [CHANNELS-1:0] fire_sel
);
   localparam int IDX_W = $clog2(CHANNELS);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(CHANNELS - 1);

   logic [IDX_W-1:0] idx_q;
   logic             tick;

   generate
      if (STEP_CYC == 1) begin : g_nodiv
         assign tick = busy;
      end else begin : g_div
         localparam int CNT_W = $clog2(STEP_CYC);
         localparam logic [CNT_W-1:0] CNT_END = CNT_W'(STEP_CYC - 1);
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n || start || cancel || !busy) cnt_q <= '0;
            else if (cnt_q == CNT_END)              cnt_q <= '0;
            else                                    cnt_q <= cnt_q + CNT_W'(1);
         end
         assign tick = busy && (cnt_q == CNT_END);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || cancel) begin
         busy  <= 1'b0;
         idx_q <= '0;
      end else if (start) begin
         busy  <= 1'b1;
         idx_q <= IDX_W'(1);
      end else if (tick) begin
         if (idx_q == LAST) busy  <= 1'b0;
         else               idx_q <= idx_q + IDX_W'(1);
      end
   end

   generate
      for (genvar k = 0; k < CHANNELS; k++) begin : g_sel
         if (k == 0) begin : g_first
            assign fire_sel[k] = start;
         end else begin : g_rest
            assign fire_sel[k] = tick && !start && (idx_q == IDX_W'(k));
         end
      end
   endgenerate

   // R5: at most one channel is loaded per edge
   assert_sel_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fire_sel));
   // R5: the walking index stays inside channels 1..N-1
   assert_idx_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (idx_q >= IDX_W'(1) && idx_q <= LAST));
   // R9: a trigger raises busy on the next edge
   assert_start_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !cancel) |=> busy);
   // R8: cancel drops busy on the next edge
   assert_cancel_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cancel |=> !busy);
endmodule

// File: rtl/lss_drive_bank.sv
`timescale 1ns/1ps
module lss_drive_bank #(
   parameter int CHANNELS = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                blank,
   input  logic                start,
   input  logic [CHANNELS-1:0] pattern,
   input  logic [CHANNELS-1:0] fire_sel,
   output logic [CHANNELS-1:0] drive
);
   logic [CHANNELS-1:1] snap_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     snap_q <= '0;
      else if (start) snap_q <= pattern[CHANNELS-1:1];
   end

   generate
      for (genvar k = 0; k < CHANNELS; k++) begin : g_ch
         logic q;
         logic nxt;
         if (k == 0) begin : g_live
            assign nxt = pattern[0];
         end else begin : g_snap
            assign nxt = snap_q[k];
         end
         always_ff @(posedge clk) begin
            if (!rst_n || blank)  q <= 1'b0;
            else if (fire_sel[k]) q <= nxt;
         end
         assign drive[k] = q;
      end
   endgenerate

   // R8: blanking clears every line on the next edge
   assert_blank_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      blank |=> (drive == '0));
   // R2: channel 0 follows the live pattern on the trigger edge
   assert_ch0_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !blank) |=> (drive[0] == $past(pattern[0])));
endmodule

// File: rtl/led_stagger_seq.sv
`timescale 1ns/1ps
module led_stagger_seq #(
   parameter int CHANNELS      = 16,
   parameter int CLK_PERIOD_PS = 20000,
   parameter int STEP_PS       = 20000
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                out_en_n,
   input  logic                latch_en,
   input  logic                shift_clk,
   input  logic [CHANNELS-1:0] pattern,
   output logic [CHANNELS-1:0] drive,
   output logic                busy
);
   localparam int STEP_CYC = lss_pkg::step_cycles(STEP_PS, CLK_PERIOD_PS);

   initial begin
      assert_cfg_channels: assert (CHANNELS >= 2)
         else $error("CHANNELS must be at least 2");
      assert_cfg_step: assert (STEP_CYC >= 1 && (STEP_PS % CLK_PERIOD_PS) == 0)
         else $error("STEP_PS must be a whole positive multiple of CLK_PERIOD_PS");
   end

   lss_pkg::pin_sample_t pins;
   logic fire, blank;
   logic [CHANNELS-1:0] fire_sel;

   assign pins.oe_n = out_en_n;
   assign pins.le   = latch_en;
   assign pins.sck  = shift_clk;

   lss_trigger trig_i (
      .clk   (clk),
      .rst_n (rst_n),
      .pins  (pins),
      .fire  (fire),
      .blank (blank)
   );

   lss_step_timer #(.CHANNELS(CHANNELS), .STEP_CYC(STEP_CYC)) timer_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (fire),
      .cancel   (blank),
      .busy     (busy),
      .fire_sel (fire_sel)
   );

   lss_drive_bank #(.CHANNELS(CHANNELS)) bank_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .blank    (blank),
      .start    (fire),
      .pattern  (pattern),
      .fire_sel (fire_sel),
      .drive    (drive)
   );

   // R10: outputs hold when idle and untriggered
   assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!fire && !busy && !out_en_n) |=> $stable(drive));
   // R1: reset leaves the block idle and dark
   assert_reset_state_R1: assert property (@(posedge clk)
      !rst_n |=> (drive == '0 && !busy));
endmodule

// File: tb/led_stagger_seq_tb_top.sv
`timescale 1ns/1ps
module led_stagger_seq_tb_top;
   localparam int N      = 5;
   localparam int CLK_PS = 20000;
   localparam int STP_PS = 60000;
   localparam int STEP   = STP_PS / CLK_PS;
   localparam int RIP    = (N - 1) * STEP;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic out_en_n = 1'b1, latch_en = 1'b0, shift_clk = 1'b0;
   logic [N-1:0] pattern = '0;
   logic [N-1:0] drive;
   logic busy;

   always #10 clk = ~clk;

   led_stagger_seq #(.CHANNELS(N), .CLK_PERIOD_PS(CLK_PS), .STEP_PS(STP_PS)) dut_i (
      .clk(clk), .rst_n(rst_n), .out_en_n(out_en_n), .latch_en(latch_en),
      .shift_clk(shift_clk), .pattern(pattern), .drive(drive), .busy(busy));

   int checks = 0, errors = 0;
   logic [N-1:0] ref_pat = '0, ref_prev = '0, last_exp = '0;
   int  ref_c = 0;
   bit  ref_off = 1'b1;

   task automatic step_check(input string tag);
      logic [N-1:0] e;
      logic eb;
      @(negedge clk);
      if (ref_off) begin
         e = '0; eb = 1'b0;
      end else begin
         for (int k = 0; k < N; k++) e[k] = (ref_c >= k * STEP) ? ref_pat[k] : ref_prev[k];
         eb = (ref_c < RIP);
         ref_c++;
      end
      checks++;
      if (drive !== e || busy !== eb) begin
         errors++;
         $display("FAIL %s: drive=%b busy=%b expected drive=%b busy=%b", tag, drive, busy, e, eb);
      end
      last_exp = e;
   endtask

   task automatic arm(input logic [N-1:0] p);
      ref_prev = last_exp; ref_pat = p; ref_c = 0; ref_off = 1'b0;
   endtask

   task automatic run(input int n, input string tag);
      for (int i = 0; i < n; i++) step_check(tag);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      run(2, "R1 reset state");

      // R2: output enable falling starts a ripple
      pattern = 5'b10110; out_en_n = 1'b0; arm(pattern);
      run(RIP + 2, "R2/R5/R9 oe fall ripple");

      // R3 sweep over every pattern, R6 pattern changed mid-ripple
      for (int p = 0; p < 32; p++) begin
         pattern = N'(p); latch_en = 1'b1; arm(N'(p));
         step_check("R3 le rise ch0");
         pattern = ~N'(p);
         run(RIP + 1, "R3/R5/R6 le rise ripple");
         latch_en = 1'b0;
         step_check("R3 le fall no trigger");
      end

      // R4: bypass shift-clock trigger
      pattern = 5'b01101; latch_en = 1'b1; arm(pattern);
      run(RIP + 1, "R4 setup");
      pattern = 5'b11010; shift_clk = 1'b1; arm(pattern);
      run(RIP + 1, "R4 shift clock bypass ripple");
      shift_clk = 1'b0; latch_en = 1'b0;
      step_check("R4 release");
      // R4/R10: shift clock with latch strobe low changes nothing
      pattern = 5'b00101; shift_clk = 1'b1;
      run(3, "R4 shift clock without strobe");
      shift_clk = 1'b0;
      run(3, "R10 idle hold");

      // R7: restart mid-ripple from channel 0
      pattern = 5'b11111; latch_en = 1'b1; arm(pattern);
      run(4, "R7 first ripple");
      pattern = 5'b01010; shift_clk = 1'b1; arm(pattern);
      run(RIP + 2, "R7 restarted ripple");
      shift_clk = 1'b0; latch_en = 1'b0;
      step_check("R7 release");

      // R8: blanking mid-ripple
      pattern = 5'b10101; latch_en = 1'b1; arm(pattern);
      run(3, "R8 ripple before blank");
      out_en_n = 1'b1; ref_off = 1'b1;
      run(RIP + 2, "R8 blank cancels ripple");

      // R11: strobe and shift clock while disabled
      latch_en = 1'b0; step_check("R11 setup");
      latch_en = 1'b1; step_check("R11 le rise while disabled");
      shift_clk = 1'b1; run(3, "R11 shift clock while disabled");
      shift_clk = 1'b0; latch_en = 1'b0;
      step_check("R11 release");

      // R2 again from dark, then R10 hold against pattern changes
      pattern = 5'b01111; out_en_n = 1'b0; arm(pattern);
      run(RIP + 1, "R2 second oe fall");
      pattern = 5'b10000;
      run(5, "R10 pattern change ignored");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule